// File: doc/BRIEF.md
# Three-Address Jump-Chained Sequencer

This block is a small multi-cycle processing core in which no instruction follows another by position. Each instruction word names two source operands, a destination and the address of its successor. One step computes `C = A op B` and then transfers control to `D`. Program and data live in the same word-addressed memory. The block reaches that memory through a single-port synchronous bus with a read latency of one cycle.

A one-cycle `start` pulse taken while the core is idle sets the first fetch address from `start_addr`. The core then runs until it fetches a stop instruction. At that point it returns to idle, raises `done` and presents the address of the stopping word on `halt_addr`. Two sticky flags record an unknown opcode and any arithmetic carry or borrow seen since the last start.

Top module: `tpo_core`

## Requirements
- R1: After reset the core is idle. `busy`, `done`, `illegal_op`, `carry_flag`, `mem_rd_en` and `mem_wr_en` are all low, and `halt_addr` is 0.
- R2: A `start` sampled high while idle makes the core read the word at `start_addr` in the next cycle, with `mem_rd_en` high and `mem_addr` equal to `start_addr`. The same start clears `done`, `illegal_op` and `carry_flag`.
- R3: An instruction word is 44 bits wide. Bits [43:40] hold the opcode. Bits [39:30] hold source address A, bits [29:20] source address B, bits [19:10] the destination and bits [9:0] the successor address.
- R4: Opcode 1 stores (word at A + word at B) mod 2^44 at the destination.
- R5: Opcode 2 stores (word at A − word at B) mod 2^44 at the destination.
- R6: The next fetch is always from the successor field, never from an incremented address. Each arithmetic instruction takes exactly five cycles: fetch, read A, read B, compute, write. After N arithmetic instructions and a final stop, `done` rises 5N+2 clock edges after the edge that sampled `start`.
- R7: Opcode 0 stops the core without any write. `busy` falls, `done` rises and `halt_addr` shows the address the stop word was fetched from.
- R8: Opcodes 3 to 15 stop the core exactly as opcode 0 does, and in addition set `illegal_op`. Opcode 0 leaves `illegal_op` low.
- R9: `carry_flag` is set by any addition whose true sum is 2^44 or more, and by any subtraction with A < B. Once set, it stays set until the next accepted start.
- R10: When the destination equals the successor address, the next fetch returns the word that has just been written.
- R11: A `start` pulse while `busy` is high has no effect on the program's results, its timing or `halt_addr`.
- R12: The core never reads and writes memory in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin execution (taken only when idle) |
| start_addr | input | 10 | Address of the first instruction |
| mem_addr | output | 10 | Memory word address |
| mem_rd_en | output | 1 | Read request; data returns next cycle |
| mem_wr_en | output | 1 | Write request |
| mem_wdata | output | 44 | Write data |
| mem_rdata | input | 44 | Read data, one cycle after the request |
| busy | output | 1 | Core is executing |
| done | output | 1 | Core has stopped on a stop instruction |
| illegal_op | output | 1 | Last stop was caused by an unknown opcode |
| carry_flag | output | 1 | Sticky carry/borrow since the last start |
| halt_addr | output | 10 | Address of the current or stopping instruction |

## Verification
The fetch read for a start is due one edge after `start` is sampled. The results of an arithmetic instruction land in memory at its fifth edge, and the successor fetch is issued in the cycle after that. `done` rises 5N+2 edges after the start edge for N arithmetic instructions. The bench drives and samples only on falling edges and counts edges from the start pulse. It compares that count against 5N+2 and reads back memory, `halt_addr` and the flags once `done` is seen. Stimulus is a full 16×16 operand sweep for both operations, chosen to hit carry and borrow boundaries, plus scattered jump chains, every unknown opcode and a self-overwriting step.

// File: rtl/tpo_pkg.sv
package tpo_pkg;
  parameter int unsigned OP_W   = 4;
  parameter int unsigned ADDR_W = 10;

  localparam int unsigned OPC_HALT = 0;
  localparam int unsigned OPC_ADD  = 1;
  localparam int unsigned OPC_SUB  = 2;

  typedef enum logic [2:0] {
    S_IDLE,
    S_FETCH,
    S_READ_A,
    S_READ_B,
    S_EXEC,
    S_WRITE_C
  } tpo_state_t;
endpackage

// File: rtl/tpo_decode.sv
module tpo_decode #(
  parameter int unsigned OP_W   = tpo_pkg::OP_W,
  parameter int unsigned ADDR_W = tpo_pkg::ADDR_W,
  localparam int unsigned W     = OP_W + 4 * ADDR_W
) (
  input  logic [W-1:0]      word,
  output logic [ADDR_W-1:0] f_a,
  output logic [ADDR_W-1:0] f_b,
  output logic [ADDR_W-1:0] f_c,
  output logic [ADDR_W-1:0] f_d,
  output logic              is_sub,
  output logic              is_stop,
  output logic              is_illegal
);
  logic [OP_W-1:0] op;

  assign op  = word[W-1 -: OP_W];
  assign f_a = word[4*ADDR_W-1 -: ADDR_W];
  assign f_b = word[3*ADDR_W-1 -: ADDR_W];
  assign f_c = word[2*ADDR_W-1 -: ADDR_W];
  assign f_d = word[ADDR_W-1:0];

  always_comb begin
    is_sub     = (op == OP_W'(tpo_pkg::OPC_SUB));
    is_illegal = (op != OP_W'(tpo_pkg::OPC_HALT)) &&
                 (op != OP_W'(tpo_pkg::OPC_ADD))  &&
                 (op != OP_W'(tpo_pkg::OPC_SUB));
    is_stop    = is_illegal || (op == OP_W'(tpo_pkg::OPC_HALT));
  end
endmodule

// File: rtl/tpo_alu.sv
module tpo_alu #(
  parameter int unsigned W = 44
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] res,
  output logic         flag
);
  // Bit W of the widened result is the carry-out (add) or borrow (sub).
  function automatic logic [W:0] wide_add(input logic [W-1:0] x, input logic [W-1:0] y);
    return {1'b0, x} + {1'b0, y};
  endfunction

  function automatic logic [W:0] wide_sub(input logic [W-1:0] x, input logic [W-1:0] y);
    return {1'b0, x} - {1'b0, y};
  endfunction

  logic [W:0] wide;

  always_comb begin
    wide = sub ? wide_sub(a, b) : wide_add(a, b);
    res  = wide[W-1:0];
    flag = wide[W];
  end
endmodule

// File: rtl/tpo_ctrl.sv
module tpo_ctrl (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                stop_now,
  output tpo_pkg::tpo_state_t st
);
  import tpo_pkg::*;

  tpo_state_t st_nx;

  always_comb begin
    st_nx = st;
    unique case (st)
      S_IDLE:    if (start) st_nx = S_FETCH;
      S_FETCH:   st_nx = S_READ_A;
      S_READ_A:  st_nx = stop_now ? S_IDLE : S_READ_B;
      S_READ_B:  st_nx = S_EXEC;
      S_EXEC:    st_nx = S_WRITE_C;
      S_WRITE_C: st_nx = S_FETCH;
      default:   st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= S_IDLE;
    else        st <= st_nx;
  end
endmodule

// File: rtl/tpo_core.sv
module tpo_core #(
  parameter int unsigned OP_W   = tpo_pkg::OP_W,
  parameter int unsigned ADDR_W = tpo_pkg::ADDR_W,
  localparam int unsigned W     = OP_W + 4 * ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd_en,
  output logic              mem_wr_en,
  output logic [W-1:0]      mem_wdata,
  input  logic [W-1:0]      mem_rdata,
  output logic              busy,
  output logic              done,
  output logic              illegal_op,
  output logic              carry_flag,
  output logic [ADDR_W-1:0] halt_addr
);
  import tpo_pkg::*;

  tpo_state_t          st;
  logic [W-1:0]        ir_q, opa_q, res_q;
  logic [ADDR_W-1:0]   pc_q;
  logic                done_q, ill_q, cry_q;

  logic [W-1:0]        dec_word;
  logic [ADDR_W-1:0]   dec_f1, dec_f2, dec_f3, dec_f4;
  logic                dec_sub, dec_stop, dec_illegal;
  logic [W-1:0]        alu_res;
  logic                alu_flag;

  // Named events used by the checker.
  logic ev_start, ev_stop, ev_retire;

  assign ev_start  = (st == S_IDLE) && start;
  assign ev_stop   = (st == S_READ_A) && dec_stop;
  assign ev_retire = (st == S_WRITE_C);

  // The fetched word is decoded straight off the bus so the A read can issue at once.
  assign dec_word = (st == S_READ_A) ? mem_rdata : ir_q;

  tpo_decode #(.OP_W(OP_W), .ADDR_W(ADDR_W)) u_dec (
    .word       (dec_word),
    .f_a        (dec_f1),
    .f_b        (dec_f2),
    .f_c        (dec_f3),
    .f_d        (dec_f4),
    .is_sub     (dec_sub),
    .is_stop    (dec_stop),
    .is_illegal (dec_illegal)
  );

  tpo_alu #(.W(W)) u_alu (
    .a    (opa_q),
    .b    (mem_rdata),
    .sub  (dec_sub),
    .res  (alu_res),
    .flag (alu_flag)
  );

  tpo_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .stop_now (dec_stop),
    .st       (st)
  );

  always_comb begin
    mem_addr  = pc_q;
    mem_rd_en = 1'b0;
    mem_wr_en = 1'b0;
    unique case (st)
      S_FETCH:   mem_rd_en = 1'b1;
      S_READ_A:  begin mem_addr = dec_f1; mem_rd_en = !dec_stop; end
      S_READ_B:  begin mem_addr = dec_f2; mem_rd_en = 1'b1; end
      S_WRITE_C: begin mem_addr = dec_f3; mem_wr_en = 1'b1; end
      default:   ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ir_q   <= '0;
      opa_q  <= '0;
      res_q  <= '0;
      pc_q   <= '0;
      done_q <= 1'b0;
      ill_q  <= 1'b0;
      cry_q  <= 1'b0;
    end else begin
      if (ev_start) begin
        pc_q   <= start_addr;
        done_q <= 1'b0;
        ill_q  <= 1'b0;
        cry_q  <= 1'b0;
      end
      if (st == S_READ_A) begin
        ir_q <= mem_rdata;
        if (dec_stop) begin
          done_q <= 1'b1;
          ill_q  <= dec_illegal;
        end
      end
      if (st == S_READ_B) opa_q <= mem_rdata;
      if (st == S_EXEC) begin
        res_q <= alu_res;
        if (alu_flag) cry_q <= 1'b1;
      end
      if (ev_retire) pc_q <= dec_f4;
    end
  end

  assign mem_wdata  = res_q;
  assign busy       = (st != S_IDLE);
  assign done       = done_q;
  assign illegal_op = ill_q;
  assign carry_flag = cry_q;
  assign halt_addr  = pc_q;
endmodule

// File: rtl/tpo_core_chk.sv
module tpo_core_chk #(
  parameter int unsigned ADDR_W = tpo_pkg::ADDR_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [ADDR_W-1:0] start_addr,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_rd_en,
  input logic              mem_wr_en,
  input logic              busy,
  input logic              done,
  input logic              ev_start,
  input logic              ev_stop,
  input logic              ev_retire,
  input logic [ADDR_W-1:0] dec_f4
);
  a_r12_one_access: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_en && mem_wr_en));

  a_r2_first_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> (mem_rd_en && mem_addr == $past(start_addr)));

  a_r6_jump_to_d: assert property (@(posedge clk) disable iff (!rst_n)
    ev_retire |=> (mem_rd_en && mem_addr == $past(dec_f4)));

  a_r6_exec_gap: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> (!$past(mem_rd_en) && !$past(mem_wr_en)));

  a_r7_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> (done && !busy && !mem_wr_en));

  a_r7_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !mem_rd_en && !mem_wr_en));

  a_r11_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !ev_stop) |=> busy);
endmodule

bind tpo_core tpo_core_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .start_addr (start_addr),
  .mem_addr   (mem_addr),
  .mem_rd_en  (mem_rd_en),
  .mem_wr_en  (mem_wr_en),
  .busy       (busy),
  .done       (done),
  .ev_start   (ev_start),
  .ev_stop    (ev_stop),
  .ev_retire  (ev_retire),
  .dec_f4     (dec_f4)
);

// File: tb/tpo_core_test.sv
`timescale 1ns/1ps
module tpo_core_test;
  localparam int AW = 10;
  localparam int DW = 44;
  localparam logic [DW-1:0] MAXV = {DW{1'b1}};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [AW-1:0] mem_addr;
  logic mem_rd_en, mem_wr_en;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata = '0;
  logic busy, done, illegal_op, carry_flag;
  logic [AW-1:0] halt_addr;

  logic ld_en = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [DW-1:0] ld_data = '0;
  logic [DW-1:0] mem [1024];

  int checks = 0;
  int failures = 0;
  int overlaps = 0;
  int writes = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  tpo_core uut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .mem_addr(mem_addr), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .busy(busy), .done(done),
    .illegal_op(illegal_op), .carry_flag(carry_flag), .halt_addr(halt_addr)
  );

  always_ff @(posedge clk) begin
    if (ld_en) mem[ld_addr] <= ld_data;
    else if (mem_wr_en) mem[mem_addr] <= mem_wdata;
    if (mem_rd_en) mem_rdata <= mem[mem_addr];
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_rd_en && mem_wr_en) overlaps++;
      if (mem_wr_en) writes++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] mk(input int op, input int a, input int b, input int c, input int d);
    return {op[3:0], a[9:0], b[9:0], c[9:0], d[9:0]};
  endfunction

  function automatic logic [DW-1:0] val(input int i);
    case (i)
      0: return 44'd0;            1: return 44'd1;
      2: return 44'd2;            3: return 44'd3;
      4: return MAXV >> 1;        5: return (MAXV >> 1) + 44'd1;
      6: return MAXV - 44'd1;     7: return MAXV;
      8: return 44'h123456789AB;  9: return 44'hFEDCBA98765;
      10: return 44'h55555555555; 11: return 44'hAAAAAAAAAAA;
      12: return 44'd4194304;     13: return 44'd4194303;
      14: return 44'd1000;        default: return 44'h80000000001;
    endcase
  endfunction

  task automatic load(input int a, input logic [DW-1:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_addr = a[AW-1:0]; ld_data = d;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  // Returns edges from the start-sampling edge to the edge that raised done.
  task automatic run(input int a, input int inject, output int cyc);
    @(negedge clk);
    start = 1'b1; start_addr = a[AW-1:0];
    @(negedge clk);
    start = 1'b0;
    chk(mem_rd_en && mem_addr == a[AW-1:0], "R2 first fetch", {53'd0, mem_rd_en, mem_addr}, {54'd1, a[AW-1:0]});
    cyc = 0;
    while (!done && cyc < 300) begin
      if (cyc == inject) begin start = 1'b1; start_addr = 10'd777; end
      @(negedge clk);
      start = 1'b0;
      cyc++;
    end
    if (cyc >= 300) chk(1'b0, "run timeout", 64'(cyc), 64'd0);
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int cyc;
    int w0;
    logic [DW-1:0] a, b, e;
    bit cf;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !illegal_op && !carry_flag, "R1 flags",
        {busy, done, illegal_op, carry_flag}, 64'd0);
    chk(!mem_rd_en && !mem_wr_en && halt_addr == '0, "R1 bus idle",
        {mem_rd_en, mem_wr_en, halt_addr}, 64'd0);
    rst_n = 1'b1;

    // R4 / R5 / R9 operand sweep, 16x16 for add and sub
    load(101, mk(0, 0, 0, 0, 0));
    for (int op = 1; op <= 2; op++) begin
      load(100, mk(op, 200, 201, 202, 101));
      for (int i = 0; i < 16; i++) begin
        for (int j = 0; j < 16; j++) begin
          a = val(i); b = val(j);
          load(200, a); load(201, b);
          run(100, -1, cyc);
          if (op == 1) begin
            e  = a + b;
            cf = (a > MAXV - b);
            chk(mem[202] == e, "R4 sum", mem[202], e);
          end else begin
            e  = a - b;
            cf = (a < b);
            chk(mem[202] == e, "R5 difference", mem[202], e);
          end
          chk(carry_flag == cf, "R9 carry/borrow", carry_flag, cf);
          chk(cyc == 7 && halt_addr == 10'd101, "R6 timing and successor",
              {cyc[31:0], 22'd0, halt_addr}, {32'd7, 22'd0, 10'd101});
        end
      end
    end

    // R3 / R6 scattered jump chain
    load(600, 44'd5); load(601, 44'd7); load(603, 44'd2);
    load(517, mk(1, 600, 601, 602, 3));
    load(3,   mk(2, 602, 603, 604, 900));
    load(900, mk(1, 604, 604, 605, 1023));
    load(1023, mk(1, 605, 600, 0, 42));
    load(42,  mk(0, 1, 2, 3, 4));
    run(517, -1, cyc);
    chk(cyc == 22, "R6 chain cycles", 64'(cyc), 64'd22);
    chk(halt_addr == 10'd42, "R6 chain halt_addr", halt_addr, 64'd42);
    chk(mem[605] == 44'd20 && mem[0] == 44'd25, "R3 chain fields", {mem[605][19:0], mem[0][19:0]}, {20'd20, 20'd25});

    // R11 start during busy ignored
    load(0, 44'd0); load(605, 44'd0);
    run(517, 3, cyc);
    chk(cyc == 22 && halt_addr == 10'd42, "R11 busy start ignored",
        {cyc[31:0], 22'd0, halt_addr}, {32'd22, 22'd0, 10'd42});
    chk(mem[0] == 44'd25, "R11 results kept", mem[0], 64'd25);

    // R7 direct stop
    load(300, mk(0, 5, 6, 7, 8));
    w0 = writes;
    run(300, -1, cyc);
    chk(cyc == 2 && done && !busy, "R7 stop timing", {cyc[31:0], done, busy}, {32'd2, 2'b10});
    chk(halt_addr == 10'd300 && !illegal_op && writes == w0, "R7 stop address, no write",
        {halt_addr, illegal_op, 32'(writes - w0)}, {10'd300, 33'd0});

    // R8 every unknown opcode
    for (int op = 3; op < 16; op++) begin
      load(310, mk(op, 400, 401, 402, 403));
      w0 = writes;
      run(310, -1, cyc);
      chk(illegal_op && cyc == 2 && halt_addr == 10'd310 && writes == w0, "R8 illegal stop",
          {illegal_op, cyc[7:0], halt_addr, 8'(writes - w0)}, {1'b1, 8'd2, 10'd310, 8'd0});
    end
    run(300, -1, cyc);
    chk(!illegal_op, "R8 opcode 0 not illegal", illegal_op, 64'd0);

    // R9 sticky across instructions, cleared by start
    load(710, MAXV); load(711, 44'd1); load(712, 44'd1);
    load(700, mk(1, 710, 711, 713, 701));
    load(701, mk(1, 712, 712, 714, 702));
    load(702, mk(0, 0, 0, 0, 0));
    run(700, -1, cyc);
    chk(carry_flag, "R9 sticky", carry_flag, 64'd1);
    run(701, -1, cyc);
    chk(!carry_flag, "R9 cleared by start", carry_flag, 64'd0);

    // R10 destination equals successor
    load(60, 44'd0);
    load(61, mk(0, 1, 2, 3, 9));
    load(51, mk(15, 0, 0, 0, 0));
    load(50, mk(1, 60, 61, 51, 51));
    run(50, -1, cyc);
    chk(halt_addr == 10'd51 && !illegal_op && cyc == 7, "R10 fetch sees new word",
        {halt_addr, illegal_op, cyc[7:0]}, {10'd51, 1'b0, 8'd7});
    chk(mem[51] == mk(0, 1, 2, 3, 9), "R10 written word", mem[51], mk(0, 1, 2, 3, 9));

    // R12 overlap monitor
    chk(overlaps == 0, "R12 single access", 64'(overlaps), 64'd0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule